// File: doc/BRIEF.md
# Local Interrupt Priority Arbiter

This block sits next to a processor core and decides which of 256 interrupt vectors the core should take next. Three 256-bit state arrays record, for each vector, whether it is requested, whether it is currently being serviced, and whether it arrived level- or edge-triggered. A task-priority register written by software and the class of the highest vector in service together set a processor priority. Any request whose 16-vector class does not exceed that priority is held back.

The core sees a registered interrupt-request level. When the core acknowledges, it gets one of three answers: nothing to take, a real vector, or the programmed spurious vector when the best request is held back. A real vector moves from the requested array to the in-service array. An end-of-interrupt strobe retires the highest vector in service. If that vector was level-triggered, and the suppress bit is clear, the block emits a one-cycle broadcast pulse that carries the retired vector number for upstream interrupt sources.

Top module: `lirq_arbiter`

## Requirements
- R1: Among the requested vectors, the one offered on acknowledge is the highest-numbered set bit of the 256-bit requested array.
- R2: The processor priority (`ppr_out`) equals the task priority when its bits 7:4 are at least bits 7:4 of the highest in-service vector. Otherwise it equals that vector's bits 7:4 followed by four zero bits. An empty in-service array counts as vector 0.
- R3: While bit 8 (enable) of the spurious register is 0, `irq_out` stays low and every acknowledge answers kind 0 (none) with vector 0.
- R4: A pending vector is blocked when the processor priority is nonzero and the vector's bits 7:4 are less than or equal to the priority's bits 7:4. An acknowledge of a blocked vector answers kind 2 (spurious) with spurious register bits 7:0, and changes no array.
- R5: An acknowledge of an unblocked vector answers kind 1 (vector) with that vector. It clears the vector's requested bit and sets its in-service bit. `ack_done` pulses for one cycle, in the cycle after `ack_stb`.
- R6: A set strobe sets the vector's requested bit. It sets the vector's trigger-mode bit when `set_level` is 1 and clears it when `set_level` is 0.
- R7: End-of-interrupt clears only the highest in-service bit. In the next cycle, `eoi_bcast` pulses with `eoi_bcast_vec` equal to that vector, but only if its trigger-mode bit is 1 and spurious register bit 12 (broadcast suppress) is 0.
- R8: A spurious-register write stores only bits 8:0 and bit 12 of `spur_wdata`. All other bits of `spur_out` read 0. The reset value is 0x00FF, which means disabled with spurious vector 0xFF.
- R9: `irq_out` is a register. It goes high in the cycle after the arrays and priority present an unblocked pending vector, and goes low in the cycle after they stop doing so.
- R10: End-of-interrupt with an empty in-service array produces no broadcast and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_stb | input | 1 | Request strobe for `set_vec` |
| set_vec | input | 8 | Vector being requested |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_stb | input | 1 | Core acknowledge strobe |
| eoi_stb | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task-priority write enable |
| tpr_wdata | input | 8 | Task-priority write value |
| spur_wr | input | 1 | Spurious-register write enable |
| spur_wdata | input | 16 | Spurious-register write value |
| irq_out | output | 1 | Registered interrupt request to the core |
| ack_done | output | 1 | Acknowledge answer valid (one cycle) |
| ack_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vec | output | 8 | Vector answered on acknowledge |
| eoi_bcast | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | 8 | Retired vector carried by the broadcast |
| tpr_out | output | 8 | Current task priority |
| ppr_out | output | 8 | Current processor priority |
| spur_out | output | 16 | Current spurious register |

## Verification
A stale or wrong requested bit shows up at the next acknowledge as a wrong or missing vector. It also shows on `irq_out` one cycle after the bad state forms. A wrong in-service bit shows at once on `ppr_out`, and at the next end-of-interrupt as a wrong retire order. A wrong trigger-mode bit stays hidden until that vector is retired, when the broadcast pulse is missing or unexpected. The directed scenarios therefore pair each state change with the port event that exposes it: a following acknowledge, a priority read, or an end-of-interrupt.

// File: rtl/lirq_pkg.sv
// Package: shared constants and answer encoding for the local interrupt
// priority arbiter. Assumes 8-bit vectors and a 16-bit spurious register.
package lirq_pkg;
    localparam int VEC_W         = 8;
    localparam int NUM_VEC       = 1 << VEC_W;
    localparam int CLASS_W       = 4;
    localparam int SPUR_W        = 16;
    localparam int SPUR_EN_BIT   = 8;
    localparam int SPUR_SUPP_BIT = 12;
    localparam logic [SPUR_W-1:0] SPUR_KEEP  = 16'h11FF;
    localparam logic [SPUR_W-1:0] SPUR_RESET = 16'h00FF;

    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_VEC  = 2'd1,
        ACK_SPUR = 2'd2
    } ack_kind_t;
endpackage

// File: rtl/lirq_prio_enc.sv
// Module: highest-set-bit finder over an N-bit vector array.
// Splits the array into WORD_W-bit words, finds the top bit in each word
// and then picks the highest non-empty word. Assumes N/WORD_W and WORD_W
// are powers of two.
module lirq_prio_enc #(
    parameter int N      = 256,
    parameter int WORD_W = 32
) (
    input  logic [N-1:0]         vec_i,
    output logic                 any_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int NW  = N / WORD_W;
    localparam int BW  = $clog2(WORD_W);
    localparam int WSW = (NW > 1) ? $clog2(NW) : 1;

    logic [NW-1:0]         word_any;
    logic [NW-1:0][BW-1:0] word_bit;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [BW-1:0] bit_l;
        // Top set bit inside this word (lower bits overwritten by higher).
        always_comb begin
            bit_l = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (vec_i[w*WORD_W + b]) bit_l = BW'(b);
            end
        end
        assign word_any[w] = |vec_i[w*WORD_W +: WORD_W];
        assign word_bit[w] = bit_l;
    end

    logic [WSW-1:0] sel;
    // Highest non-empty word wins.
    always_comb begin
        sel = '0;
        for (int w = 0; w < NW; w++) begin
            if (word_any[w]) sel = WSW'(w);
        end
    end

    assign any_o = |word_any;
    assign idx_o = $clog2(N)'({sel, word_bit[sel]});
endmodule

// File: rtl/lirq_vec_state.sv
// Module: the requested, in-service and trigger-mode arrays.
// Assumes that a take (acknowledge) and a retire (end-of-interrupt) each
// name a vector whose source bit is already known to be set.
module lirq_vec_state #(
    parameter int VEC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_stb,
    input  logic [VEC_W-1:0]      set_vec,
    input  logic                  set_level,
    input  logic                  take_stb,
    input  logic [VEC_W-1:0]      take_vec,
    input  logic                  retire_stb,
    input  logic [VEC_W-1:0]      retire_vec,
    output logic [(1<<VEC_W)-1:0] req_arr,
    output logic [(1<<VEC_W)-1:0] svc_arr,
    output logic [(1<<VEC_W)-1:0] lvl_arr
);
    localparam int N = 1 << VEC_W;

    logic [N-1:0] set_oh, take_oh, retire_oh;

    assign set_oh    = set_stb    ? (N'(1) << set_vec)    : '0;
    assign take_oh   = take_stb   ? (N'(1) << take_vec)   : '0;
    assign retire_oh = retire_stb ? (N'(1) << retire_vec) : '0;

    // Requested array: new requests join, taken vectors leave.
    always_ff @(posedge clk) begin
        if (!rst_n) req_arr <= '0;
        else        req_arr <= (req_arr & ~take_oh) | set_oh;
    end

    // In-service array: taken vectors join, retired vector leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_arr <= '0;
        else        svc_arr <= (svc_arr & ~retire_oh) | take_oh;
    end

    // Trigger-mode array: each request records its own trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_arr <= '0;
        else if (set_stb) lvl_arr[set_vec] <= set_level;
    end
endmodule

// File: rtl/lirq_priority.sv
// Module: processor-priority and blocking decision (pure combinational).
// Assumes priority classes are the top CLASS_W bits of a vector.
module lirq_priority #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             svc_any,
    input  logic [VEC_W-1:0] svc_top,
    input  logic             req_any,
    input  logic [VEC_W-1:0] req_top,
    input  logic             enable,
    output logic [VEC_W-1:0] ppr,
    output logic             blocked,
    output logic             deliver
);
    localparam int LOW_W = VEC_W - CLASS_W;

    logic [CLASS_W-1:0] svc_class;

    assign svc_class = svc_any ? svc_top[VEC_W-1 -: CLASS_W] : '0;

    // Priority: task priority unless the in-service class is higher.
    always_comb begin
        if (tpr[VEC_W-1 -: CLASS_W] >= svc_class) ppr = tpr;
        else                                      ppr = {svc_class, {LOW_W{1'b0}}};
    end

    assign blocked = (ppr != '0) &&
                     (req_top[VEC_W-1 -: CLASS_W] <= ppr[VEC_W-1 -: CLASS_W]);
    assign deliver = enable && req_any && !blocked;
endmodule

// File: rtl/lirq_arbiter.sv
// Module: local interrupt priority arbiter top.
// Holds the task-priority and spurious registers, ties the vector arrays to
// two priority encoders and the blocking logic, and registers every answer
// to the core. Assumes the strobes are single-cycle pulses from one master.
module lirq_arbiter
    import lirq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic [VEC_W-1:0]  set_vec,
    input  logic              set_level,
    input  logic              ack_stb,
    input  logic              eoi_stb,
    input  logic              tpr_wr,
    input  logic [VEC_W-1:0]  tpr_wdata,
    input  logic              spur_wr,
    input  logic [SPUR_W-1:0] spur_wdata,
    output logic              irq_out,
    output logic              ack_done,
    output logic [1:0]        ack_kind,
    output logic [VEC_W-1:0]  ack_vec,
    output logic              eoi_bcast,
    output logic [VEC_W-1:0]  eoi_bcast_vec,
    output logic [VEC_W-1:0]  tpr_out,
    output logic [VEC_W-1:0]  ppr_out,
    output logic [SPUR_W-1:0] spur_out
);
    logic [VEC_W-1:0]   tpr_q;
    logic [SPUR_W-1:0]  spur_q;
    logic [NUM_VEC-1:0] req_arr, svc_arr, lvl_arr;
    logic               req_any, svc_any;
    logic [VEC_W-1:0]   req_top, svc_top, ppr;
    logic               blocked, deliver, enable;
    logic               take, retire;

    assign enable = spur_q[SPUR_EN_BIT];
    assign take   = ack_stb && deliver;
    assign retire = eoi_stb && svc_any;

    // Task-priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_wr) tpr_q <= tpr_wdata;
    end

    // Spurious register keeps only its defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       spur_q <= SPUR_RESET;
        else if (spur_wr) spur_q <= spur_wdata & SPUR_KEEP;
    end

    lirq_vec_state #(.VEC_W(VEC_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_stb    (set_stb),
        .set_vec    (set_vec),
        .set_level  (set_level),
        .take_stb   (take),
        .take_vec   (req_top),
        .retire_stb (retire),
        .retire_vec (svc_top),
        .req_arr    (req_arr),
        .svc_arr    (svc_arr),
        .lvl_arr    (lvl_arr)
    );

    lirq_prio_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_req_enc (
        .vec_i (req_arr),
        .any_o (req_any),
        .idx_o (req_top)
    );

    lirq_prio_enc #(.N(NUM_VEC), .WORD_W(WORD_W)) u_svc_enc (
        .vec_i (svc_arr),
        .any_o (svc_any),
        .idx_o (svc_top)
    );

    lirq_priority #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
        .tpr     (tpr_q),
        .svc_any (svc_any),
        .svc_top (svc_top),
        .req_any (req_any),
        .req_top (req_top),
        .enable  (enable),
        .ppr     (ppr),
        .blocked (blocked),
        .deliver (deliver)
    );

    // Registered request level to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= deliver;
    end

    // Acknowledge answer: none, real vector, or spurious vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done <= 1'b0;
            ack_kind <= ACK_NONE;
            ack_vec  <= '0;
        end else begin
            ack_done <= ack_stb;
            if (ack_stb) begin
                if (!enable || !req_any) begin
                    ack_kind <= ACK_NONE;
                    ack_vec  <= '0;
                end else if (blocked) begin
                    ack_kind <= ACK_SPUR;
                    ack_vec  <= spur_q[VEC_W-1:0];
                end else begin
                    ack_kind <= ACK_VEC;
                    ack_vec  <= req_top;
                end
            end
        end
    end

    // Broadcast pulse for a retired level-triggered vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast     <= 1'b0;
            eoi_bcast_vec <= '0;
        end else begin
            eoi_bcast <= retire && lvl_arr[svc_top] && !spur_q[SPUR_SUPP_BIT];
            if (retire) eoi_bcast_vec <= svc_top;
        end
    end

    assign tpr_out  = tpr_q;
    assign ppr_out  = ppr;
    assign spur_out = spur_q;
endmodule

// File: rtl/lirq_arbiter_chk.sv
// Module: port-level property checker for lirq_arbiter, bound to the top.
module lirq_arbiter_chk
    import lirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ack_stb,
    input logic              eoi_stb,
    input logic              irq_out,
    input logic              ack_done,
    input logic [1:0]        ack_kind,
    input logic [VEC_W-1:0]  ack_vec,
    input logic              eoi_bcast,
    input logic [VEC_W-1:0]  tpr_out,
    input logic [VEC_W-1:0]  ppr_out,
    input logic [SPUR_W-1:0] spur_out
);
    // R3: a request to the core needs the enable bit one cycle earlier.
    p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(spur_out[SPUR_EN_BIT]));

    // R3: a disabled arbiter answers none.
    p_ack_none_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !$past(spur_out[SPUR_EN_BIT])) |-> (ack_kind == ACK_NONE));

    // R2: processor priority never drops below task priority.
    p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_out >= tpr_out);

    // R4: a spurious answer carries the spurious register vector.
    p_spur_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_kind == ACK_SPUR) |-> (ack_vec == $past(spur_out[VEC_W-1:0])));

    // R5: an answer only follows an acknowledge strobe.
    p_ack_follows_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |-> $past(ack_stb));

    // R7: a broadcast only follows an end-of-interrupt strobe.
    p_bcast_follows_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi_stb));

    // R8: undefined spurious bits always read zero.
    p_spur_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (spur_out & ~SPUR_KEEP) == '0);
endmodule

bind lirq_arbiter lirq_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_stb   (ack_stb),
    .eoi_stb   (eoi_stb),
    .irq_out   (irq_out),
    .ack_done  (ack_done),
    .ack_kind  (ack_kind),
    .ack_vec   (ack_vec),
    .eoi_bcast (eoi_bcast),
    .tpr_out   (tpr_out),
    .ppr_out   (ppr_out),
    .spur_out  (spur_out)
);

// File: tb/lirq_arbiter_bench.sv
// Bench: directed scenarios for lirq_arbiter, one task each.
module lirq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_stb = 1'b0;
    logic [7:0]  set_vec = '0;
    logic        set_level = 1'b0;
    logic        ack_stb = 1'b0;
    logic        eoi_stb = 1'b0;
    logic        tpr_wr = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        spur_wr = 1'b0;
    logic [15:0] spur_wdata = '0;
    logic        irq_out, ack_done, eoi_bcast;
    logic [1:0]  ack_kind;
    logic [7:0]  ack_vec, eoi_bcast_vec, tpr_out, ppr_out;
    logic [15:0] spur_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lirq_arbiter u_lirq_arbiter (
        .clk(clk), .rst_n(rst_n),
        .set_stb(set_stb), .set_vec(set_vec), .set_level(set_level),
        .ack_stb(ack_stb), .eoi_stb(eoi_stb),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .spur_wr(spur_wr), .spur_wdata(spur_wdata),
        .irq_out(irq_out), .ack_done(ack_done), .ack_kind(ack_kind),
        .ack_vec(ack_vec), .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec),
        .tpr_out(tpr_out), .ppr_out(ppr_out), .spur_out(spur_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_set(input logic [7:0] v, input logic lvl);
        @(negedge clk); set_stb = 1'b1; set_vec = v; set_level = lvl;
        @(negedge clk); set_stb = 1'b0;
    endtask

    task automatic do_tpr(input logic [7:0] v);
        @(negedge clk); tpr_wr = 1'b1; tpr_wdata = v;
        @(negedge clk); tpr_wr = 1'b0;
    endtask

    task automatic do_spur(input logic [15:0] v);
        @(negedge clk); spur_wr = 1'b1; spur_wdata = v;
        @(negedge clk); spur_wr = 1'b0;
    endtask

    // Acknowledge and compare the answer (valid the cycle after the strobe).
    task automatic do_ack(input string req, input logic [1:0] kind, input logic [7:0] vec);
        @(negedge clk); ack_stb = 1'b1;
        @(negedge clk); ack_stb = 1'b0;
        chk(req, "ack_done", ack_done, 1);
        chk(req, "ack_kind", ack_kind, kind);
        chk(req, "ack_vec", ack_vec, vec);
    endtask

    // End-of-interrupt and compare the broadcast pulse.
    task automatic do_eoi(input string req, input logic bc, input logic [7:0] vec);
        @(negedge clk); eoi_stb = 1'b1;
        @(negedge clk); eoi_stb = 1'b0;
        chk(req, "eoi_bcast", eoi_bcast, bc);
        if (bc) chk(req, "eoi_bcast_vec", eoi_bcast_vec, vec);
    endtask

    task automatic settle_irq(input string req, input logic exp);
        @(negedge clk);
        chk(req, "irq_out", irq_out, exp);
    endtask

    task automatic t_reset;
        chk("R8", "spur_out reset", spur_out, 16'h00FF);
        chk("R9", "irq_out reset", irq_out, 0);
        chk("R5", "ack_done reset", ack_done, 0);
        chk("R7", "eoi_bcast reset", eoi_bcast, 0);
        chk("R2", "ppr_out reset", ppr_out, 0);
    endtask

    task automatic t_disabled;
        do_set(8'h40, 1'b0);
        settle_irq("R3", 0);
        do_ack("R3", 2'd0, 8'h00);
    endtask

    task automatic t_spur_write;
        do_spur(16'hF1A5);
        chk("R8", "spur masked", spur_out, 16'h11A5);
        do_spur(16'h0120);
        chk("R8", "spur plain", spur_out, 16'h0120);
    endtask

    task automatic t_highest;
        do_set(8'h91, 1'b0);
        do_set(8'h3F, 1'b0);
        settle_irq("R9", 1);
        do_ack("R1", 2'd1, 8'h91);
        chk("R2", "ppr after 0x91 taken", ppr_out, 8'h90);
    endtask

    task automatic t_blocked;
        settle_irq("R9", 0);
        do_ack("R4", 2'd2, 8'h20);
        do_eoi("R7", 1'b0, 8'h00);
        do_tpr(8'h45);
        chk("R2", "ppr equals tpr", ppr_out, 8'h45);
        do_ack("R4", 2'd2, 8'h20);
        do_tpr(8'h35);
        do_ack("R5", 2'd1, 8'h40);
        chk("R2", "ppr from in-service class", ppr_out, 8'h40);
        do_tpr(8'h50);
        chk("R2", "ppr back to tpr", ppr_out, 8'h50);
        do_tpr(8'h00);
    endtask

    task automatic t_level_eoi;
        do_set(8'h77, 1'b1);
        do_ack("R5", 2'd1, 8'h77);
        do_eoi("R7", 1'b1, 8'h77);
        do_eoi("R7", 1'b0, 8'h00);
        chk("R7", "ppr after both retired", ppr_out, 8'h00);
    endtask

    task automatic t_retrigger;
        do_set(8'h77, 1'b1);
        do_set(8'h77, 1'b0);
        do_ack("R6", 2'd1, 8'h77);
        do_eoi("R6", 1'b0, 8'h00);
    endtask

    task automatic t_suppress;
        do_spur(16'h1120);
        do_set(8'h66, 1'b1);
        do_ack("R7", 2'd1, 8'h66);
        do_eoi("R7", 1'b0, 8'h00);
        do_spur(16'h0120);
    endtask

    task automatic t_empty_eoi;
        do_eoi("R10", 1'b0, 8'h00);
        chk("R10", "ppr unchanged", ppr_out, 8'h00);
        do_ack("R10", 2'd1, 8'h3F);
        settle_irq("R9", 0);
        do_ack("R3", 2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_spur_write;
        t_highest;
        t_blocked;
        t_level_eoi;
        t_retrigger;
        t_suppress;
        t_empty_eoi;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule